// File: doc/BRIEF.md
# Cipher Configuration Register Front-End

This block is the register file that sits in front of a block cipher engine. It stores one control word, eight 32-bit initial key words and four 32-bit initialisation-vector words. Each is written through a simple single-cycle write port and read back through a combinational read port. The engine's busy signal is an input. While it is high, every configuration write is dropped, so a running operation can never see its key, IV or mode change underneath it.

The block gives the engine the effective key for the selected length, with unused words forced to zero. It also gives the current 128-bit IV and an IV-valid flag. IV-valid rises only once all four IV words have been written since the last reset or clear, in any order. In counter mode the engine pulses an increment input. The IV then advances by one, treated as a big-endian 128-bit integer, even though its register words are little-endian. A start request is granted only when the unit is idle and, for the chaining and counter modes, the IV is valid.

Top module: `cipher_cfg_regs`

## Requirements
- R1: After reset all stored words, the control value and the IV-written record are zero, `iv_valid` is 0 and `key_out` is 0.
- R2: While `eng_busy` is 1, writes to the control word, any key word or any IV word have no effect on stored values or on the IV-written record.
- R3: Address map: 0 is control, 1..8 are key words 0..7, 9..12 are IV words 0..3. Each address reads back its last accepted value. Control bits [1:0] are the mode (0 ECB, 1 CBC, 2 CTR, 3 behaves as ECB) and bits [3:2] are the key length (0 = 128, 1 = 192, 2 or 3 = 256); the upper control bits read as zero.
- R4: `key_out` word k (bits 32k+31:32k) carries key word k when k is below 4, 6 or 8 words for 128-, 192- or 256-bit length, and zero otherwise. Unused key words stay stored and readable.
- R5: `iv_valid` is 1 exactly when each of the four IV words has had an accepted write since the last reset or clear. Order is free, and repeated writes to one word count once.
- R6: A pulse on `iv_clear` clears the IV-written record, so `iv_valid` is 0 in the next cycle. Clear wins over a same-cycle IV write. Stored IV values are kept.
- R7: In CTR mode, a `ctr_inc` pulse replaces the IV in one cycle. The 16 bytes of the IV are read with byte 0 (bits 7:0 of IV word 0) as most significant. One is added with carry across all 128 bits, and the sum is stored back in the same byte order. All-ones wraps to all-zeros.
- R8: `start_go` is `start_req` AND idle AND (mode is ECB or mode 3, or `iv_valid` is 1).
- R9: `idle` is the inverse of `eng_busy`. A write presented while `idle` is 1 at a clock edge is accepted even if `eng_busy` rises right after that edge.
- R10: `ctr_inc` has no effect outside CTR mode. It also has no effect in a cycle where an IV-word write is accepted; that write takes effect instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 4 | Write word address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Read word address |
| rd_data | output | 32 | Read data (combinational) |
| eng_busy | input | 1 | Engine busy |
| start_req | input | 1 | Start request from the engine sequencer |
| iv_clear | input | 1 | Clears the IV-written record |
| ctr_inc | input | 1 | Counter-mode IV increment request |
| idle | output | 1 | Unit idle |
| iv_valid | output | 1 | All IV words written |
| start_go | output | 1 | Start granted |
| mode | output | 2 | Current mode field |
| key_len | output | 2 | Current key-length field |
| key_out | output | 256 | Effective key, word k at bits 32k+31:32k |
| iv_out | output | 128 | Current IV, word k at bits 32k+31:32k |

## Verification
The hardest situation to reach is a counter-mode increment whose carry has to ripple across byte and word boundaries in big-endian order. The carry runs from the top byte of the last IV word down into lower-numbered words. The bench loads IV patterns with runs of 0xFF bytes at the least significant end of the big-endian value. These include the all-ones value that wraps. It then compares the result against a byte-wise carry loop. A second hard case is a write that coincides with an increment or with the busy edge. The bench times both with single-cycle strobes placed on the same negative edge.

// File: rtl/cipher_cfg_regs.sv
module cipher_cfg_regs #(
  parameter int DW       = 32,
  parameter int KEY_WDS  = 8,
  parameter int IV_WDS   = 4,
  parameter int AW       = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [AW-1:0]           wr_addr,
  input  logic [DW-1:0]           wr_data,
  input  logic [AW-1:0]           rd_addr,
  output logic [DW-1:0]           rd_data,
  input  logic                    eng_busy,
  input  logic                    start_req,
  input  logic                    iv_clear,
  input  logic                    ctr_inc,
  output logic                    idle,
  output logic                    iv_valid,
  output logic                    start_go,
  output logic [1:0]              mode,
  output logic [1:0]              key_len,
  output logic [DW*KEY_WDS-1:0]   key_out,
  output logic [DW*IV_WDS-1:0]    iv_out
);
  localparam int KEY_BASE = 1;
  localparam int IV_BASE  = KEY_BASE + KEY_WDS;
  localparam int KW       = DW * KEY_WDS;
  localparam int IVW      = DW * IV_WDS;
  localparam int IVB      = IVW / 8;
  localparam int CW       = 4;
  localparam logic [1:0] M_CBC = 2'd1;
  localparam logic [1:0] M_CTR = 2'd2;

  logic [CW-1:0]     ctrl_q;
  logic [KW-1:0]     key_q;
  logic [IVW-1:0]    iv_q;
  logic [IV_WDS-1:0] seen_q;

  logic wr_ok, iv_hit, inc_fire, needs_iv;
  logic [IVW-1:0] iv_be, iv_be_inc, iv_next;
  logic [4:0] used_wds;

  assign idle     = ~eng_busy;
  assign wr_ok    = wr_en & idle;
  assign iv_hit   = wr_ok && int'(wr_addr) >= IV_BASE && int'(wr_addr) < IV_BASE + IV_WDS;
  assign mode     = ctrl_q[1:0];
  assign key_len  = ctrl_q[3:2];
  assign needs_iv = (mode == M_CBC) || (mode == M_CTR);
  assign inc_fire = ctr_inc && (mode == M_CTR) && !iv_hit;
  assign iv_valid = &seen_q;
  assign start_go = start_req & idle & (~needs_iv | iv_valid);
  assign iv_out   = iv_q;

  // big-endian increment over little-endian byte storage
  for (genvar b = 0; b < IVB; b++) begin : g_swap
    assign iv_be[8*b +: 8]   = iv_q[8*(IVB-1-b) +: 8];
    assign iv_next[8*b +: 8] = iv_be_inc[8*(IVB-1-b) +: 8];
  end
  assign iv_be_inc = iv_be + 1'b1;

  always_comb begin
    case (key_len)
      2'd0:    used_wds = 5'd4;
      2'd1:    used_wds = 5'd6;
      default: used_wds = 5'(KEY_WDS);
    endcase
  end

  for (genvar w = 0; w < KEY_WDS; w++) begin : g_key
    assign key_out[DW*w +: DW] = (w < int'(used_wds)) ? key_q[DW*w +: DW] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      key_q  <= '0;
      iv_q   <= '0;
      seen_q <= '0;
    end else begin
      if (wr_ok && int'(wr_addr) == 0) ctrl_q <= wr_data[CW-1:0];
      for (int k = 0; k < KEY_WDS; k++)
        if (wr_ok && int'(wr_addr) == KEY_BASE + k) key_q[DW*k +: DW] <= wr_data;
      if (inc_fire) iv_q <= iv_next;
      for (int k = 0; k < IV_WDS; k++)
        if (wr_ok && int'(wr_addr) == IV_BASE + k) begin
          iv_q[DW*k +: DW] <= wr_data;
          seen_q[k]        <= 1'b1;
        end
      if (iv_clear) seen_q <= '0;
    end
  end

  always_comb begin
    rd_data = '0;
    if (int'(rd_addr) == 0) rd_data = {{(DW-CW){1'b0}}, ctrl_q};
    for (int k = 0; k < KEY_WDS; k++)
      if (int'(rd_addr) == KEY_BASE + k) rd_data = key_q[DW*k +: DW];
    for (int k = 0; k < IV_WDS; k++)
      if (int'(rd_addr) == IV_BASE + k) rd_data = iv_q[DW*k +: DW];
  end

  p_busy_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |=> $stable(ctrl_q) && $stable(key_q));
  p_busy_iv_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && !inc_fire) |=> $stable(iv_q));
  p_busy_seen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |=> !$rose(iv_valid));
  p_valid_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(iv_valid) |-> $past(iv_hit));
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    iv_clear |=> !iv_valid);
  p_inc_moves_r7: assert property (@(posedge clk) disable iff (!rst_n)
    inc_fire |=> iv_q != $past(iv_q));
  p_start_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_go |-> idle && (!needs_iv || iv_valid));
  p_inc_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctr_inc && mode != M_CTR && !wr_ok) |=> $stable(iv_q));
endmodule

// File: tb/cipher_cfg_regs_bench.sv
module cipher_cfg_regs_bench;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, eng_busy = 0, start_req = 0, iv_clear = 0, ctr_inc = 0;
  logic [3:0] wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic idle, iv_valid, start_go;
  logic [1:0] mode, key_len;
  logic [255:0] key_out;
  logic [127:0] iv_out;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cipher_cfg_regs u_cipher_cfg_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .eng_busy(eng_busy), .start_req(start_req),
    .iv_clear(iv_clear), .ctr_inc(ctr_inc), .idle(idle), .iv_valid(iv_valid),
    .start_go(start_go), .mode(mode), .key_len(key_len), .key_out(key_out), .iv_out(iv_out));

  task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic pulse_clear();
    @(negedge clk); iv_clear = 1; @(negedge clk); iv_clear = 0;
  endtask

  task automatic pulse_inc();
    @(negedge clk); ctr_inc = 1; @(negedge clk); ctr_inc = 0;
  endtask

  task automatic set_iv(input logic [127:0] v);
    for (int k = 0; k < 4; k++) wr(4'(9 + k), v[32*k +: 32]);
  endtask

  function automatic logic [127:0] be_inc(input logic [127:0] v);
    logic [127:0] r = v;
    logic c = 1;
    for (int i = 15; i >= 0; i--) begin
      {c, r[8*i +: 8]} = {1'b0, v[8*i +: 8]} + 9'(c);
    end
    return r;
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    rd(0, d);
    chk("R1 ctrl after reset", 256'(d), 0);
    chk("R1 iv_valid after reset", 256'(iv_valid), 0);
    chk("R1 key_out after reset", key_out, 0);
    chk("R9 idle when not busy", 256'(idle), 1);
  endtask

  task automatic t_readback();
    logic [31:0] d;
    wr(0, 32'h0000_0009);
    for (int k = 0; k < 8; k++) wr(4'(1 + k), 32'hA000_0000 + 32'(k));
    rd(0, d);  chk("R3 ctrl readback", 256'(d), 9);
    rd(6, d);  chk("R3 key5 readback", 256'(d), 256'h A000_0005);
    chk("R3 mode field", 256'(mode), 1);
    chk("R3 key_len field", 256'(key_len), 2);
  endtask

  task automatic t_keylen();
    logic [255:0] full;
    logic [31:0] d;
    for (int k = 0; k < 8; k++) full[32*k +: 32] = 32'hA000_0000 + 32'(k);
    chk("R4 256-bit key", key_out, full);
    wr(0, 32'h0000_0000);
    chk("R4 128-bit key", key_out, {128'h0, full[127:0]});
    wr(0, 32'h0000_0004);
    chk("R4 192-bit key", key_out, {64'h0, full[191:0]});
    rd(8, d); chk("R4 unused key7 still stored", 256'(d), 256'hA000_0007);
  endtask

  task automatic t_iv_valid();
    pulse_clear();
    wr(11, 32'h2222_2222); wr(9, 32'h0000_0000); wr(11, 32'h3333_3333); wr(12, 32'h4444_4444);
    chk("R5 three words, one repeated", 256'(iv_valid), 0);
    wr(10, 32'h1111_1111);
    chk("R5 all four written", 256'(iv_valid), 1);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    pulse_clear();
    chk("R6 clear drops iv_valid", 256'(iv_valid), 0);
    rd(11, d); chk("R6 iv2 kept after clear", 256'(d), 256'h3333_3333);
    @(negedge clk); iv_clear = 1; wr_en = 1; wr_addr = 9; wr_data = 32'h5;
    @(negedge clk); iv_clear = 0; wr_en = 0;
    set_iv({32'h4444_4444, 32'h3333_3333, 32'h1111_1111, 32'h0});
    chk("R6 clear then rewrite", 256'(iv_valid), 1);
  endtask

  task automatic t_busy();
    logic [31:0] d;
    pulse_clear();
    @(negedge clk); eng_busy = 1;
    wr(0, 32'h0000_000E); wr(1, 32'hDEAD_BEEF);
    set_iv(128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF);
    rd(0, d); chk("R2 ctrl unchanged while busy", 256'(d), 4);
    rd(1, d); chk("R2 key0 unchanged while busy", 256'(d), 256'hA000_0000);
    chk("R2 iv unchanged while busy", 256'(iv_out), 256'({32'h4444_4444, 32'h3333_3333, 32'h1111_1111, 32'h0}));
    chk("R2 iv_valid not set by busy writes", 256'(iv_valid), 0);
    chk("R9 idle low while busy", 256'(idle), 0);
    @(negedge clk); eng_busy = 0;
  endtask

  task automatic t_edge();
    logic [31:0] d;
    @(negedge clk); wr_en = 1; wr_addr = 2; wr_data = 32'h1234_5678;
    @(negedge clk); wr_en = 0; eng_busy = 1;
    rd(2, d); chk("R9 write before busy rise accepted", 256'(d), 256'h1234_5678);
    @(negedge clk); eng_busy = 0;
  endtask

  task automatic t_start();
    wr(0, 32'h1);
    pulse_clear();
    start_req = 1; #1;
    chk("R8 CBC held off without IV", 256'(start_go), 0);
    set_iv(128'h0);
    #1; chk("R8 CBC granted with IV", 256'(start_go), 1);
    eng_busy = 1; #1;
    chk("R8 no grant while busy", 256'(start_go), 0);
    eng_busy = 0;
    wr(0, 32'h0); pulse_clear(); #1;
    chk("R8 ECB granted without IV", 256'(start_go), 1);
    wr(0, 32'h2); #1;
    chk("R8 CTR held off without IV", 256'(start_go), 0);
    @(negedge clk); start_req = 0;
  endtask

  task automatic t_ctr();
    logic [127:0] v;
    wr(0, 32'h2);
    v = {32'hFFFF_FFFF, 32'hFFFF_FF07, 32'h0, 32'h0};
    set_iv(v);
    @(negedge clk); eng_busy = 1;
    pulse_inc();
    chk("R7 carry across bytes and words", 256'(iv_out), 256'(be_inc(v)));
    v = be_inc(v);
    pulse_inc();
    chk("R7 second increment", 256'(iv_out), 256'(be_inc(v)));
    @(negedge clk); eng_busy = 0;
    v = '1; set_iv(v);
    pulse_inc();
    chk("R7 wrap all-ones to zero", 256'(iv_out), 0);
    v = 128'h0100_0000_0000_0000_0000_0000_0000_0000; set_iv(v);
    pulse_inc();
    chk("R7 top byte increments last byte order", 256'(iv_out), 256'(be_inc(v)));
  endtask

  task automatic t_inc_ignored();
    logic [127:0] v;
    v = 128'h0123_4567_89AB_CDEF_0011_2233_4455_6677;
    set_iv(v);
    wr(0, 32'h1);
    pulse_inc();
    chk("R10 no increment in CBC", 256'(iv_out), 256'(v));
    wr(0, 32'h2);
    @(negedge clk); ctr_inc = 1; wr_en = 1; wr_addr = 9; wr_data = 32'hCAFE_0000;
    @(negedge clk); ctr_inc = 0; wr_en = 0;
    chk("R10 write wins over increment", 256'(iv_out), 256'({v[127:32], 32'hCAFE_0000}));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_readback();
    t_keylen();
    t_iv_valid();
    t_clear();
    t_busy();
    t_edge();
    t_start();
    t_ctr();
    t_inc_ignored();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog (all R) actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule